// File: doc/BRIEF.md
# Cascadable Four-Bit Processor Slice

This block is one narrow column of a microprogrammed data path. Each slice holds two things: a sixteen-entry register file and an auxiliary Q register, both four bits wide. It also holds operand selection, an eight-function ALU and a one-bit shifter. Every clock it runs one nine-bit micro-operation. The three-bit field in bits 2:0 picks the operand pair. The field in bits 5:3 picks the ALU function. The field in bits 8:6 picks where the result goes.

Identical slices sit side by side to form a wider word. The carry runs from each slice to the one above it. The shift links for the register path and the Q path join neighbouring slices, so a one-bit shift carries bits across slice boundaries. Each slice also drives a group generate and a group propagate term, which an external lookahead unit can use in place of the ripple.

The top level stacks a parameter-chosen number of slices with ripple carry. At the two outer ends of the word it drives the vacated shift bit from a fill parameter, which defaults to zero.

Top module: `bslice_cascade`

## Requirements
- R1: A clock edge with `rst` high clears every register-file entry and the Q register of every slice to zero.
- R2: `uop[2:0]` selects the operand pair (R,S): 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0). A is the entry at `a_addr`, B is the entry at `b_addr`, and D is `din`.
- R3: `uop[5:3]` selects the ALU result F: 0=R+S+cin, 1=S+~R+cin, 2=R+~S+cin, 3=R|S, 4=R&S, 5=~R&S, 6=R^S, 7=~(R^S). The result is computed over the whole word.
- R4: For functions 0 to 2, `cout` is the carry out of the word's top bit, and carries ripple from slice to slice. For functions 3 to 7, `cout` is 0.
- R5: For functions 0 to 2, `slice_g[k]` is 1 exactly when slice k's four-bit effective operands produce a carry with carry-in 0, and `slice_p[k]` is 1 exactly when every one of its four bit positions propagates. For functions 3 to 7, both are 0.
- R6: `uop[8:6]` selects the write action. 0 writes F to Q. 1 writes nothing. 2 and 3 write F to register B. Codes 4 to 7 write a shifted F to register B.
- R7: Codes 4 and 5 write F shifted one place toward the LSB into B. Codes 6 and 7 write F shifted one place toward the MSB into B. Codes 4 and 6 also shift Q the same way. The vacated bit at each word end is 0, and bits move across slice boundaries.
- R8: `rf_lo_o` and `rf_hi_o` equal F bit 0 and F's top bit. `q_lo_o` and `q_hi_o` equal Q bit 0 and Q's top bit.
- R9: `dout` equals A when `uop[8:6]`=2, and F otherwise.
- R10: Register and Q writes take effect only at the rising edge. Outputs are combinational from the inputs and the stored state, so an operation reads the old contents even when it writes the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | 4 | Register-file address for operand A |
| b_addr | input | 4 | Register-file address for operand B and for writes |
| uop | input | 9 | Micro-operation: destination 8:6, function 5:3, source 2:0 |
| din | input | 4*SLICES | Direct data operand D |
| cin | input | 1 | Carry into the lowest slice |
| dout | output | 4*SLICES | Data output, A or F |
| cout | output | 1 | Carry out of the highest slice |
| slice_g | output | SLICES | Group generate term of each slice |
| slice_p | output | SLICES | Group propagate term of each slice |
| rf_lo_o | output | 1 | F bit 0, the bit that leaves on a down shift |
| rf_hi_o | output | 1 | F top bit, the bit that leaves on an up shift |
| q_lo_o | output | 1 | Q bit 0 |
| q_hi_o | output | 1 | Q top bit |

## Verification
`dout`, `cout`, the generate and propagate terms and the shift-out pins are due in the same cycle as the micro-operation. The bench drives the inputs on the falling edge and samples them one time unit later, before the next rising edge. A write to register B or Q becomes visible only after the next rising edge. The bench's model updates its register copy at that edge, and a later operation reads the entry back through A or Q to check it. That read-back also shows that an operation writing its own source still reads the old value in its own cycle.

// File: rtl/bslice_pkg.sv
package bslice_pkg;

    localparam int SLICE_W = 4;

    typedef enum logic [2:0] {
        SRC_AQ = 3'd0,
        SRC_AB = 3'd1,
        SRC_ZQ = 3'd2,
        SRC_ZB = 3'd3,
        SRC_ZA = 3'd4,
        SRC_DA = 3'd5,
        SRC_DQ = 3'd6,
        SRC_DZ = 3'd7
    } src_e;

    typedef enum logic [2:0] {
        FN_ADD  = 3'd0,
        FN_SUBR = 3'd1,
        FN_SUBS = 3'd2,
        FN_OR   = 3'd3,
        FN_AND  = 3'd4,
        FN_NRS  = 3'd5,
        FN_XOR  = 3'd6,
        FN_XNOR = 3'd7
    } fn_e;

    typedef enum logic [2:0] {
        DST_QREG  = 3'd0,
        DST_NOP   = 3'd1,
        DST_RAMA  = 3'd2,
        DST_RAMF  = 3'd3,
        DST_RAMQD = 3'd4,
        DST_RAMD  = 3'd5,
        DST_RAMQU = 3'd6,
        DST_RAMU  = 3'd7
    } dst_e;

    typedef struct packed {
        dst_e dst;
        fn_e  fn;
        src_e src;
    } uop_t;

    function automatic logic is_arith(fn_e f);
        return (f == FN_ADD) || (f == FN_SUBR) || (f == FN_SUBS);
    endfunction

    function automatic logic writes_b(dst_e d);
        return (d != DST_QREG) && (d != DST_NOP);
    endfunction

    function automatic logic writes_q(dst_e d);
        return (d == DST_QREG) || (d == DST_RAMQD) || (d == DST_RAMQU);
    endfunction

endpackage

// File: rtl/bslice_regfile.sv
module bslice_regfile #(
    parameter int W  = 4,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] a_addr,
    input  logic [AW-1:0] b_addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  a_data,
    output logic [W-1:0]  b_data
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[b_addr] <= wdata;
        end
    end

    assign a_data = mem[a_addr];
    assign b_data = mem[b_addr];

    // R1: entries at both ends of the file are clear once reset drops
    a_r1_regs_cleared: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem[0] == '0 && mem[DEPTH-1] == '0));

endmodule

// File: rtl/bslice_alu.sv
module bslice_alu
    import bslice_pkg::*;
#(
    parameter int W = 4
) (
    input  src_e         src,
    input  fn_e          fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] d,
    input  logic [W-1:0] q,
    input  logic         cin,
    output logic [W-1:0] f,
    output logic         cout,
    output logic         g,
    output logic         p
);
    logic [W-1:0] r, s, r_eff, s_eff;
    logic [W:0]   sum;
    logic [W-1:0] gb, pb, gc;

    always_comb begin
        unique case (src)
            SRC_AQ:  begin r = a;  s = q;  end
            SRC_AB:  begin r = a;  s = b;  end
            SRC_ZQ:  begin r = '0; s = q;  end
            SRC_ZB:  begin r = '0; s = b;  end
            SRC_ZA:  begin r = '0; s = a;  end
            SRC_DA:  begin r = d;  s = a;  end
            SRC_DQ:  begin r = d;  s = q;  end
            default: begin r = d;  s = '0; end
        endcase
    end

    assign r_eff = (fn == FN_SUBR) ? ~r : r;
    assign s_eff = (fn == FN_SUBS) ? ~s : s;
    assign sum   = {1'b0, r_eff} + {1'b0, s_eff} + {{W{1'b0}}, cin};
    assign gb    = r_eff & s_eff;
    assign pb    = r_eff ^ s_eff;

    // Group generate built as a prefix chain over the bit terms
    assign gc[0] = gb[0];
    for (genvar i = 1; i < W; i++) begin : g_chain
        assign gc[i] = gb[i] | (pb[i] & gc[i-1]);
    end

    always_comb begin
        cout = 1'b0;
        g    = 1'b0;
        p    = 1'b0;
        unique case (fn)
            FN_ADD, FN_SUBR, FN_SUBS: begin
                f    = sum[W-1:0];
                cout = sum[W];
                g    = gc[W-1];
                p    = &pb;
            end
            FN_OR:   f = r | s;
            FN_AND:  f = r & s;
            FN_NRS:  f = ~r & s;
            FN_XOR:  f = r ^ s;
            default: f = ~(r ^ s);
        endcase
    end

endmodule

// File: rtl/bslice_unit.sv
module bslice_unit
    import bslice_pkg::*;
#(
    parameter int W  = 4,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] a_addr,
    input  logic [AW-1:0] b_addr,
    input  uop_t          u,
    input  logic [W-1:0]  din,
    input  logic          cin,
    input  logic          rf_dn_in,
    input  logic          rf_up_in,
    input  logic          q_dn_in,
    input  logic          q_up_in,
    output logic [W-1:0]  y,
    output logic          cout,
    output logic          g,
    output logic          p,
    output logic          rf_lo_out,
    output logic          rf_hi_out,
    output logic          q_lo_out,
    output logic          q_hi_out
);
    logic [W-1:0] a_data, b_data, f, wdata, q_r, q_nxt;

    bslice_regfile #(.W(W), .AW(AW)) rf_i (
        .clk    (clk),
        .rst    (rst),
        .a_addr (a_addr),
        .b_addr (b_addr),
        .we     (writes_b(u.dst)),
        .wdata  (wdata),
        .a_data (a_data),
        .b_data (b_data)
    );

    bslice_alu #(.W(W)) alu_i (
        .src  (u.src),
        .fn   (u.fn),
        .a    (a_data),
        .b    (b_data),
        .d    (din),
        .q    (q_r),
        .cin  (cin),
        .f    (f),
        .cout (cout),
        .g    (g),
        .p    (p)
    );

    always_comb begin
        unique case (u.dst)
            DST_RAMQD, DST_RAMD: wdata = {rf_dn_in, f[W-1:1]};
            DST_RAMQU, DST_RAMU: wdata = {f[W-2:0], rf_up_in};
            default:             wdata = f;
        endcase
        unique case (u.dst)
            DST_QREG:  q_nxt = f;
            DST_RAMQD: q_nxt = {q_dn_in, q_r[W-1:1]};
            DST_RAMQU: q_nxt = {q_r[W-2:0], q_up_in};
            default:   q_nxt = q_r;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= q_nxt;
    end

    assign y         = (u.dst == DST_RAMA) ? a_data : f;
    assign rf_lo_out = f[0];
    assign rf_hi_out = f[W-1];
    assign q_lo_out  = q_r[0];
    assign q_hi_out  = q_r[W-1];

    // R1: Q is clear on the first cycle after reset
    a_r1_q_cleared: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (q_r == '0));

    // R5: the slice carry agrees with its own lookahead terms
    a_r5_lookahead: assert property (@(posedge clk) disable iff (rst)
        cout == (g | (p & cin)));

    // R4, R5: logic functions raise no carry, generate or propagate
    a_r4_logic_no_carry: assert property (@(posedge clk) disable iff (rst)
        !is_arith(u.fn) |-> (!cout && !g && !p));

    // R6: Q holds when the destination does not touch it
    a_r6_q_hold: assert property (@(posedge clk) disable iff (rst)
        !writes_q(u.dst) |=> $stable(q_r));

    // R7: a down shift of Q takes the neighbour bit at its top
    a_r7_q_shift_down: assert property (@(posedge clk) disable iff (rst)
        (u.dst == DST_RAMQD) |=> (q_r == {$past(q_dn_in), $past(q_r[W-1:1])}));

endmodule

// File: rtl/bslice_cascade.sv
module bslice_cascade
    import bslice_pkg::*;
#(
    parameter int   SLICES = 4,
    parameter int   AW     = 4,
    parameter logic FILL   = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [AW-1:0]               a_addr,
    input  logic [AW-1:0]               b_addr,
    input  logic [8:0]                  uop,
    input  logic [SLICE_W*SLICES-1:0]   din,
    input  logic                        cin,
    output logic [SLICE_W*SLICES-1:0]   dout,
    output logic                        cout,
    output logic [SLICES-1:0]           slice_g,
    output logic [SLICES-1:0]           slice_p,
    output logic                        rf_lo_o,
    output logic                        rf_hi_o,
    output logic                        q_lo_o,
    output logic                        q_hi_o
);
    localparam int W = SLICE_W;

    uop_t              u;
    logic [SLICES:0]   carry;
    logic [SLICES-1:0] rf_lo, rf_hi, q_lo, q_hi;
    logic [SLICES-1:0] rf_dn, rf_up, q_dn, q_up;

    assign u        = uop_t'(uop);
    assign carry[0] = cin;

    for (genvar i = 0; i < SLICES; i++) begin : g_slice
        if (i == SLICES - 1) begin : g_top_end
            assign rf_dn[i] = FILL;
            assign q_dn[i]  = FILL;
        end else begin : g_top_link
            assign rf_dn[i] = rf_lo[i+1];
            assign q_dn[i]  = q_lo[i+1];
        end
        if (i == 0) begin : g_bot_end
            assign rf_up[i] = FILL;
            assign q_up[i]  = FILL;
        end else begin : g_bot_link
            assign rf_up[i] = rf_hi[i-1];
            assign q_up[i]  = q_hi[i-1];
        end

        bslice_unit #(.W(W), .AW(AW)) unit_i (
            .clk       (clk),
            .rst       (rst),
            .a_addr    (a_addr),
            .b_addr    (b_addr),
            .u         (u),
            .din       (din[i*W +: W]),
            .cin       (carry[i]),
            .rf_dn_in  (rf_dn[i]),
            .rf_up_in  (rf_up[i]),
            .q_dn_in   (q_dn[i]),
            .q_up_in   (q_up[i]),
            .y         (dout[i*W +: W]),
            .cout      (carry[i+1]),
            .g         (slice_g[i]),
            .p         (slice_p[i]),
            .rf_lo_out (rf_lo[i]),
            .rf_hi_out (rf_hi[i]),
            .q_lo_out  (q_lo[i]),
            .q_hi_out  (q_hi[i])
        );
    end

    assign cout    = carry[SLICES];
    assign rf_lo_o = rf_lo[0];
    assign rf_hi_o = rf_hi[SLICES-1];
    assign q_lo_o  = q_lo[0];
    assign q_hi_o  = q_hi[SLICES-1];

endmodule

// File: tb/bslice_cascade_tb.sv
module bslice_cascade_tb_top;
    localparam int CLK_P = 10;
    localparam int NS    = 2;
    localparam int DW    = 4 * NS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    a_addr = '0, b_addr = '0;
    logic [8:0]    uop = 9'h0;
    logic [DW-1:0] din = '0;
    logic          cin = 1'b0;
    logic [DW-1:0] dout;
    logic          cout, rf_lo_o, rf_hi_o, q_lo_o, q_hi_o;
    logic [NS-1:0] slice_g, slice_p;

    int checks = 0;
    int failures = 0;

    logic [DW-1:0] mreg [16];
    logic [DW-1:0] mq;
    logic [31:0]   lfsr = 32'h1234_5678;

    always #(CLK_P/2) clk = ~clk;

    bslice_cascade #(.SLICES(NS), .AW(4)) dut_i (
        .clk(clk), .rst(rst), .a_addr(a_addr), .b_addr(b_addr), .uop(uop),
        .din(din), .cin(cin), .dout(dout), .cout(cout), .slice_g(slice_g),
        .slice_p(slice_p), .rf_lo_o(rf_lo_o), .rf_hi_o(rf_hi_o),
        .q_lo_o(q_lo_o), .q_hi_o(q_hi_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] src, input logic [2:0] fn, input logic [2:0] dst,
                          input logic [3:0] aa, input logic [3:0] bb,
                          input logic [DW-1:0] d, input logic ci, input string ytag);
        logic [DW-1:0] a, b, r, s, re, se, f, y;
        logic [DW:0]   sum;
        logic          co, ar;
        logic [NS-1:0] eg, ep;
        string         t;
        @(negedge clk);
        a_addr = aa; b_addr = bb; uop = {dst, fn, src}; din = d; cin = ci;
        #1;
        a = mreg[aa]; b = mreg[bb];
        case (src)
            3'd0: begin r = a;  s = mq; end
            3'd1: begin r = a;  s = b;  end
            3'd2: begin r = '0; s = mq; end
            3'd3: begin r = '0; s = b;  end
            3'd4: begin r = '0; s = a;  end
            3'd5: begin r = d;  s = a;  end
            3'd6: begin r = d;  s = mq; end
            default: begin r = d; s = '0; end
        endcase
        ar  = (fn <= 3'd2);
        re  = (fn == 3'd1) ? ~r : r;
        se  = (fn == 3'd2) ? ~s : s;
        sum = {1'b0, re} + {1'b0, se} + (DW+1)'(ci);
        case (fn)
            3'd0, 3'd1, 3'd2: f = sum[DW-1:0];
            3'd3: f = r | s;
            3'd4: f = r & s;
            3'd5: f = ~r & s;
            3'd6: f = r ^ s;
            default: f = ~(r ^ s);
        endcase
        co = ar ? sum[DW] : 1'b0;
        for (int k = 0; k < NS; k++) begin
            logic [4:0] ns;
            ns    = {1'b0, re[4*k +: 4]} + {1'b0, se[4*k +: 4]};
            eg[k] = ar & ns[4];
            ep[k] = ar & ((re[4*k +: 4] ^ se[4*k +: 4]) == 4'hF);
        end
        y = (dst == 3'd2) ? a : f;
        t = (ytag != "") ? ytag : ((dst == 3'd2) ? "R9" : "R3");
        chk(t, 32'(dout), 32'(y));
        chk("R4 carry", 32'(cout), 32'(co));
        chk("R5 generate", 32'(slice_g), 32'(eg));
        chk("R5 propagate", 32'(slice_p), 32'(ep));
        chk("R8 shift outs", {28'h0, rf_lo_o, rf_hi_o, q_lo_o, q_hi_o},
            {28'h0, f[0], f[DW-1], mq[0], mq[DW-1]});
        @(posedge clk);
        case (dst)
            3'd0: mq = f;
            3'd2, 3'd3: mreg[bb] = f;
            3'd4: begin mreg[bb] = {1'b0, f[DW-1:1]}; mq = {1'b0, mq[DW-1:1]}; end
            3'd5: mreg[bb] = {1'b0, f[DW-1:1]};
            3'd6: begin mreg[bb] = {f[DW-2:0], 1'b0}; mq = {mq[DW-2:0], 1'b0}; end
            3'd7: mreg[bb] = {f[DW-2:0], 1'b0};
            default: ;
        endcase
    endtask

    // Read an entry through A or Q with an OR against zero, no write
    task automatic read_a(input logic [3:0] aa, input string tag);
        run_op(3'd4, 3'd3, 3'd1, aa, 4'd0, '0, 1'b0, tag);
    endtask
    task automatic read_q(input string tag);
        run_op(3'd2, 3'd3, 3'd1, 4'd0, 4'd0, '0, 1'b0, tag);
    endtask
    task automatic load(input logic [3:0] bb, input logic [DW-1:0] v);
        run_op(3'd7, 3'd3, 3'd3, 4'd0, bb, v, 1'b0, "R6 load");
    endtask

    initial begin
        #(CLK_P * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mreg[i] = '0;
        mq = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every entry and Q read back as zero after reset
        for (int i = 0; i < 16; i++) read_a(4'(i), "R1 reg");
        read_q("R1 q");

        // R6: fill the file and Q with distinct values
        for (int i = 0; i < 16; i++) load(4'(i), DW'(i * 37 + 11));
        run_op(3'd7, 3'd3, 3'd0, 4'd0, 4'd0, 8'h5A, 1'b0, "R6 q load");
        for (int i = 0; i < 16; i++) read_a(4'(i), "R6 readback");
        read_q("R6 q readback");

        // R2/R3: sweep every source, function and carry-in with no writes
        for (int fn = 0; fn < 8; fn++)
            for (int src = 0; src < 8; src++)
                for (int ci = 0; ci < 2; ci++)
                    for (int i = 0; i < 16; i++)
                        run_op(3'(src), 3'(fn), 3'd1, 4'(i), 4'((i * 5 + 3) % 16),
                               DW'(i * 29 + fn * 7 + 1), ci[0], "R2");

        // R4: carry crosses the slice boundary, and full-width overflow
        load(4'd1, 8'h0F);
        load(4'd2, 8'h01);
        run_op(3'd1, 3'd0, 3'd1, 4'd1, 4'd2, '0, 1'b0, "R4 cross slice");
        load(4'd1, 8'hFF);
        run_op(3'd1, 3'd0, 3'd1, 4'd1, 4'd2, '0, 1'b0, "R4 overflow");

        // R7: down and up shifts with and without Q
        load(4'd3, 8'h81);
        run_op(3'd7, 3'd3, 3'd0, 4'd0, 4'd0, 8'h18, 1'b0, "R6 q load");
        run_op(3'd3, 3'd3, 3'd4, 4'd0, 4'd3, '0, 1'b0, "");
        read_a(4'd3, "R7 down shift reg");
        read_q("R7 down shift q");
        run_op(3'd3, 3'd3, 3'd6, 4'd0, 4'd3, '0, 1'b0, "");
        read_a(4'd3, "R7 up shift reg");
        read_q("R7 up shift q");
        run_op(3'd3, 3'd3, 3'd7, 4'd0, 4'd3, '0, 1'b0, "");
        run_op(3'd3, 3'd3, 3'd5, 4'd0, 4'd3, '0, 1'b0, "");
        read_a(4'd3, "R7 shift no q");
        read_q("R7 q untouched");

        // R10: write to own source shows old A in the same cycle
        load(4'd4, 8'h3C);
        run_op(3'd4, 3'd0, 3'd2, 4'd4, 4'd4, '0, 1'b1, "R10 old value");
        read_a(4'd4, "R10 new value");
        run_op(3'd4, 3'd3, 3'd1, 4'd4, 4'd4, '0, 1'b0, "R6 nop");
        read_a(4'd4, "R6 nop kept");

        // Mixed operations with all destinations
        for (int n = 0; n < 3000; n++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            run_op(lfsr[2:0], lfsr[5:3], lfsr[8:6], lfsr[12:9], lfsr[16:13],
                   lfsr[24:17], lfsr[25], "");
            if (n % 50 == 0) begin
                read_a(lfsr[29:26], "R6 state");
                read_q("R7 q state");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule